// File: doc/BRIEF.md
# Edge-Triggered Manual Reset Pulse Timer

This block converts a request on a manual reset input into a reset pulse of fixed length. The input's active sense is chosen by a strap: with the strap high the input is active high, and with it low the input is active low. The input passes through a two-flop synchronizer. Only the transition into the active level starts a pulse. A steady active level does nothing further. Once a pulse starts, it lasts exactly `TICKS` clock cycles and then ends, even if the input is still held active. For example, 200 ms at a 250 MHz clock is 50,000,000 cycles.

The pulse appears on two outputs that are always complements of each other: one is active high and one is active low. A third output, the memory-disable output, tells a companion memory controller to refuse accesses. It stays high while the pulse is running. It also stays high for as long as the synchronized manual input stays active, so it outlasts the pulse when the input is held down. The polarity strap must be held static while power-on reset is released.

Top module: `mr_pulse_timer`

## Requirements
- R1: While `por_n` is low, `rst_hi_o` is 0, `rst_lo_o` is 1 and `mem_dis_o` is 1. If the manual input is already active when reset is released, no pulse starts until the input has first been seen inactive.
- R2: `rst_lo_o` equals the inverse of `rst_hi_o` in every cycle.
- R3: With `mr_pol` = 1, a low-to-high transition of `mr_in` is the active edge. `rst_hi_o` rises at the third rising clock edge after the input changes.
- R4: With `mr_pol` = 0, a high-to-low transition of `mr_in` is the active edge, with the same three-edge latency.
- R5: A pulse keeps `rst_hi_o` high for exactly `TICKS` cycles. It then drops even while the input is still held active.
- R6: An active edge that arrives while a pulse is running is ignored. It neither restarts nor extends the pulse.
- R7: `mem_dis_o` is 1 whenever a pulse is running. It is also 1 whenever the input level from two rising edges earlier was active. Otherwise it is 0.
- R8: A pulse runs its full length even if the input returns to inactive before the pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mr_in | input | 1 | Manual reset request, asynchronous |
| mr_pol | input | 1 | Input sense: 1 = active high, 0 = active low |
| rst_hi_o | output | 1 | Reset pulse, active high |
| rst_lo_o | output | 1 | Reset pulse, active low |
| mem_dis_o | output | 1 | Memory disable for the companion controller |

## Verification
The hardest case to reach is a second active edge that lands inside a running pulse. The input has to leave and re-enter its active level while the counter is still counting down. The bench does this by driving the input inactive and then active again partway through the pulse. It then measures the pulse width and checks that it is still exactly `TICKS`. The bench also exercises a release partway through the pulse and a hold past the timeout. For each of these, it models the two-cycle lag of the synchronized input and checks the memory-disable output against that model in every cycle.

// File: rtl/mr_pulse_timer.sv
module mr_pulse_timer #(
  parameter int unsigned TICKS = 50_000_000
) (
  input  logic clk,
  input  logic por_n,
  input  logic mr_in,
  input  logic mr_pol,
  output logic rst_hi_o,
  output logic rst_lo_o,
  output logic mem_dis_o
);
  localparam int CW = $clog2(TICKS + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          pulse_q;
  logic          lvl, held, rise_seen, busy;

  assign lvl       = mr_pol ? mr_in : ~mr_in;
  assign held      = sync_q[1];
  assign rise_seen = sync_q[1] & ~sync_q[2];
  assign busy      = (cnt_q != '0);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) sync_q <= '1;
    else        sync_q <= {sync_q[1:0], lvl};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)         cnt_q <= '0;
    else if (busy)      cnt_q <= cnt_q - 1'b1;
    else if (rise_seen) cnt_q <= TICKS[CW-1:0];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) pulse_q <= 1'b0;
    else        pulse_q <= busy ? (cnt_q > 1) : rise_seen;

  assign rst_hi_o  = pulse_q;
  assign rst_lo_o  = ~pulse_q;
  assign mem_dis_o = pulse_q | held;

  logic [CW:0] hi_len_q;
  always_ff @(posedge clk or negedge por_n)
    if (!por_n) hi_len_q <= '0;
    else        hi_len_q <= rst_hi_o ? hi_len_q + 1'b1 : '0;

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!por_n)
    rise_seen && !busy |=> rst_hi_o);

  // R5
  width_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_hi_o) |-> hi_len_q == TICKS);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_hi_o && cnt_q == 1 |=> !rst_hi_o);

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_hi_o && cnt_q > 1 |=> cnt_q == $past(cnt_q) - 1'b1);

  // R7
  memdis_lead_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_hi_o) |-> $past(mem_dis_o));

  // R2
  complement_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_lo_o != rst_hi_o);
endmodule

// File: tb/mr_pulse_timer_bench.sv
module mr_pulse_timer_bench;
  localparam int unsigned TICKS = 20;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic mr_in = 1'b0;
  logic mr_pol = 1'b1;
  logic rst_hi_o, rst_lo_o, mem_dis_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mr_pulse_timer #(.TICKS(TICKS)) u_mr_pulse_timer (
    .clk(clk), .por_n(por_n), .mr_in(mr_in), .mr_pol(mr_pol),
    .rst_hi_o(rst_hi_o), .rst_lo_o(rst_lo_o), .mem_dis_o(mem_dis_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic drive(input bit pol, input bit act);
    mr_in = pol ? act : ~act;
  endtask

  task automatic do_reset(input bit pol, input bit act);
    @(negedge clk);
    por_n = 1'b0;
    mr_pol = pol;
    drive(pol, act);
    cyc(2);
    chk(rst_hi_o == 1'b0, "R1 rst_hi in reset", rst_hi_o, 0);
    chk(rst_lo_o == 1'b1, "R1 rst_lo in reset", rst_lo_o, 1);
    chk(mem_dis_o == 1'b1, "R1 mem_dis in reset", mem_dis_o, 1);
    por_n = 1'b1;
    cyc(3);
  endtask

  task automatic run_pulse(input bit pol, input int hold, input int off_at,
                           input int on_at, input string tag);
    bit act_hist [0:40];
    int first = -1;
    int last = -1;
    bit cur = 1'b1;
    act_hist[0] = 1'b1;
    drive(pol, 1'b1);
    for (int s = 1; s <= 40; s++) begin
      bit exp_p, exp_m, lag;
      cyc(1);
      exp_p = (s >= 3) && (s < 3 + int'(TICKS));
      lag = (s >= 2) ? act_hist[s-2] : 1'b0;
      exp_m = exp_p | lag;
      chk(rst_hi_o == exp_p, {tag, " rst_hi"}, rst_hi_o, exp_p);
      chk(rst_lo_o == ~rst_hi_o, "R2 complement", rst_lo_o, !rst_hi_o);
      chk(mem_dis_o == exp_m, "R7 mem_dis", mem_dis_o, exp_m);
      if (rst_hi_o && first < 0) first = s;
      if (rst_hi_o) last = s;
      if (s == hold || s == off_at) cur = 1'b0;
      if (s == on_at) cur = 1'b1;
      act_hist[s] = cur;
      drive(pol, cur);
    end
    chk(first == 3, {tag, " start latency"}, first, 3);
    chk(last - first + 1 == int'(TICKS), "R5 width", last - first + 1, TICKS);
    drive(pol, 1'b0);
    cyc(4);
    chk(mem_dis_o == 1'b0, "R7 mem_dis idle", mem_dis_o, 0);
  endtask

  task automatic t_reset_held;
    do_reset(1'b1, 1'b1);
    cyc(10);
    chk(rst_hi_o == 1'b0, "R1 no pulse from held level", rst_hi_o, 0);
    chk(mem_dis_o == 1'b1, "R1 R7 mem_dis held", mem_dis_o, 1);
    drive(1'b1, 1'b0);
    cyc(2);
    chk(mem_dis_o == 1'b0, "R7 mem_dis released", mem_dis_o, 0);
    chk(rst_lo_o == 1'b1, "R2 rst_lo idle", rst_lo_o, 1);
  endtask

  initial begin
    t_reset_held();
    run_pulse(1'b1, 5, 0, 0, "R3 R8 short press");
    run_pulse(1'b1, 35, 0, 0, "R3 R5 long hold");
    run_pulse(1'b1, 0, 8, 12, "R6 retrigger");
    do_reset(1'b0, 1'b0);
    chk(mem_dis_o == 1'b0, "R1 idle after reset low pol", mem_dis_o, 0);
    run_pulse(1'b0, 30, 0, 0, "R4 low polarity");
    run_pulse(1'b0, 0, 6, 15, "R4 R6 retrigger low");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule